// File: doc/BRIEF.md
# Carrier Lock Acquisition Controller

This block decides whether a carrier tracking loop has locked. It sums the per-symbol phase error over an integration window of a programmable number of symbols. At the end of each window it compares the magnitude of that sum with a lock threshold. In parallel it sums a second, selectable error term and compares it with a false-lock threshold. The window results drive a three-state controller with the states search, verify and track.

In search the controller enables the frequency sweep and selects the acquisition loop gains. A good window moves it to verify. Verify needs a programmable run of good windows before it moves to track. A bad window sends it back to search. When enabled, a false-lock hit also sends it back to search. Once in track, the controller leaves only after a programmable run of consecutive bad windows. A processor can request a halt, which freezes the accumulators at the end of the current window so that the window sums can be read. An initialize command clears the accumulators and the window counter and releases a halt.

Top module: `carrier_lock_ctrl`

## Requirements
- R1: After reset the state is search (code 0), sweepEn=1, acqTrkSel=0, locked=0, lockIrq=0, halted=0 and phaseSum=0.
- R2: A window closes on the intCount-th accepted symbol (an intCount of 0 acts as 1). phaseSum then shows the signed sum of phaseErr over that window. The window counts as good only when |sum| < lockThresh, so a sum equal to the threshold is bad.
- R3: In search (code 0) a good window moves to verify (code 1) and a bad window keeps search. Search never goes straight to track.
- R4: In verify a bad window returns to search. After verifyNeed consecutive good windows in verify (0 acts as 1) the state becomes track (code 2).
- R5: In verify with falseLockEn=1, a window whose false-lock sum has magnitude greater than falseThresh returns to search even when the phase window is good. With falseLockEn=0 that sum has no effect.
- R6: falseSel=0 feeds freqErr into the false-lock sum. falseSel=1 feeds altErr instead.
- R7: In track, the state returns to search only after dropNeed consecutive bad windows (0 acts as 1). A good window restarts that count, and track never goes to verify.
- R8: sweepEn=1 exactly in search. acqTrkSel=1 and locked=1 exactly in track.
- R9: lockIrq is a one-cycle pulse in the same cycle that locked changes value, for both entry to and exit from track.
- R10: A haltReq pulse sets halted=1 at the end of the window in progress. While halted, symbols are ignored: phaseSum and the state stay unchanged.
- R11: An initReq pulse clears both accumulators and the window counter, and clears halted and any pending halt.
- R12: status bit 6 = locked, bit 5 = acqTrkSel, bit 4 = sweepDir, bit 3 = hiPwr, bit 2 = loPwr, bit 1 = halted; bits 7 and 0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | One symbol's error terms are present |
| phaseErr | input | ErrW | Signed phase error per symbol |
| freqErr | input | ErrW | Signed frequency error per symbol |
| altErr | input | ErrW | Signed alternate false-lock term |
| falseSel | input | 1 | False-lock source: 0 freqErr, 1 altErr |
| falseLockEn | input | 1 | Enable the false-lock check in verify |
| intCount | input | CntW | Symbols per integration window |
| lockThresh | input | AccW | Lock threshold on the phase sum magnitude |
| falseThresh | input | AccW | False-lock threshold |
| verifyNeed | input | RunW | Good windows needed in verify |
| dropNeed | input | RunW | Bad windows needed to leave track |
| haltReq | input | 1 | Halt at the end of the current window |
| initReq | input | 1 | Clear the accumulators, counter and halt |
| sweepDir | input | 1 | Sweep direction, reported in status |
| hiPwr | input | 1 | High-power flag, reported in status |
| loPwr | input | 1 | Low-power flag, reported in status |
| lockState | output | 2 | 0 search, 1 verify, 2 track |
| locked | output | 1 | Carrier lock |
| acqTrkSel | output | 1 | 0 acquisition gains, 1 tracking gains |
| sweepEn | output | 1 | Enable the frequency sweep |
| lockIrq | output | 1 | Pulse on a lock change |
| halted | output | 1 | Accumulators frozen for reading |
| phaseSum | output | AccW | Phase sum of the last closed window |
| falseSum | output | AccW | False-lock sum of the last closed window |
| status | output | 8 | Status word |

## Verification
A wrong run counter or transition shows up at lockState, or in a missing or extra lockIrq pulse. This appears one clock after the window that should have moved the state. A window counter that is off by one shows up at once as a wrong phaseSum value on the same window. A halt that leaks symbols shows up as a changed phaseSum or state while halted is high. An initialize that does not clear the accumulators shows up in the sum of the next full window.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_TRACK  = 2'd2
  } lockSt_t;

  typedef struct packed {
    logic clear;
    logic freeze;
  } ctrlStrobe_t;
endpackage

// File: rtl/lockdet_accum.sv
module lockdet_accum #(
  parameter int ErrW = 8,
  parameter int CntW = 16,
  parameter int AccW = 24
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  lockdet_pkg::ctrlStrobe_t strobe,
  input  logic                     symValid,
  input  logic signed [ErrW-1:0]   phaseErr,
  input  logic signed [ErrW-1:0]   freqErr,
  input  logic signed [ErrW-1:0]   altErr,
  input  logic                     falseSel,
  input  logic [CntW-1:0]          intCount,
  input  logic [AccW-1:0]          lockThresh,
  input  logic [AccW-1:0]          falseThresh,
  output logic                     resValid,
  output logic                     winGood,
  output logic                     winFalse,
  output logic signed [AccW-1:0]   phaseSum,
  output logic signed [AccW-1:0]   falseSum
);
  localparam int ExtW = AccW - ErrW;

  logic signed [AccW-1:0] phaseAcc, falseAcc, nextPhase, nextFalse;
  logic signed [ErrW-1:0] falseIn;
  logic [CntW-1:0]        symCnt, lastIdx;

  function automatic logic [AccW-1:0] magOf(input logic signed [AccW-1:0] v);
    return v[AccW-1] ? AccW'(-v) : AccW'(v);
  endfunction

  always_comb begin
    falseIn   = falseSel ? altErr : freqErr;
    lastIdx   = (intCount == '0) ? '0 : intCount - 1'b1;
    nextPhase = phaseAcc + {{ExtW{phaseErr[ErrW-1]}}, phaseErr};
    nextFalse = falseAcc + {{ExtW{falseIn[ErrW-1]}}, falseIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      symCnt   <= '0;
      phaseAcc <= '0;
      falseAcc <= '0;
      resValid <= 1'b0;
      winGood  <= 1'b0;
      winFalse <= 1'b0;
      phaseSum <= '0;
      falseSum <= '0;
    end else begin
      resValid <= 1'b0;
      if (strobe.clear) begin
        symCnt   <= '0;
        phaseAcc <= '0;
        falseAcc <= '0;
      end else if (symValid && !strobe.freeze) begin
        if (symCnt == lastIdx) begin
          resValid <= 1'b1;
          phaseSum <= nextPhase;
          falseSum <= nextFalse;
          winGood  <= magOf(nextPhase) < lockThresh;
          winFalse <= magOf(nextFalse) > falseThresh;
          symCnt   <= '0;
          phaseAcc <= '0;
          falseAcc <= '0;
        end else begin
          symCnt   <= symCnt + 1'b1;
          phaseAcc <= nextPhase;
          falseAcc <= nextFalse;
        end
      end
    end
  end
endmodule

// File: rtl/lockdet_fsm.sv
module lockdet_fsm #(
  parameter int RunW = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     resValid,
  input  logic                     winGood,
  input  logic                     winFalse,
  input  logic                     falseLockEn,
  input  logic [RunW-1:0]          verifyNeed,
  input  logic [RunW-1:0]          dropNeed,
  input  logic                     haltReq,
  input  logic                     initReq,
  output lockdet_pkg::ctrlStrobe_t strobe,
  output lockdet_pkg::lockSt_t     state,
  output logic                     lockIrq,
  output logic                     halted
);
  import lockdet_pkg::*;

  lockSt_t         stateNext;
  logic [RunW-1:0] runCnt, runNext, vLimit, dLimit;
  logic            haltPend;

  always_comb begin
    vLimit    = (verifyNeed == '0) ? RunW'(1) : verifyNeed;
    dLimit    = (dropNeed == '0) ? RunW'(1) : dropNeed;
    stateNext = state;
    runNext   = runCnt;
    if (resValid) begin
      unique case (state)
        ST_SEARCH: begin
          runNext = '0;
          if (winGood) stateNext = ST_VERIFY;
        end
        ST_VERIFY: begin
          if (!winGood || (falseLockEn && winFalse)) begin
            stateNext = ST_SEARCH;
            runNext   = '0;
          end else if (runCnt + 1'b1 >= vLimit) begin
            stateNext = ST_TRACK;
            runNext   = '0;
          end else begin
            runNext = runCnt + 1'b1;
          end
        end
        ST_TRACK: begin
          if (winGood) begin
            runNext = '0;
          end else if (runCnt + 1'b1 >= dLimit) begin
            stateNext = ST_SEARCH;
            runNext   = '0;
          end else begin
            runNext = runCnt + 1'b1;
          end
        end
        default: begin
          stateNext = ST_SEARCH;
          runNext   = '0;
        end
      endcase
    end
    strobe.clear  = initReq;
    strobe.freeze = halted || (haltPend && resValid);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_SEARCH;
      runCnt   <= '0;
      lockIrq  <= 1'b0;
      haltPend <= 1'b0;
      halted   <= 1'b0;
    end else begin
      state   <= stateNext;
      runCnt  <= runNext;
      lockIrq <= (stateNext == ST_TRACK) != (state == ST_TRACK);
      if (haltReq) haltPend <= 1'b1;
      if (resValid && haltPend) begin
        halted   <= 1'b1;
        haltPend <= 1'b0;
      end
      if (initReq) begin
        halted   <= 1'b0;
        haltPend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/carrier_lock_ctrl.sv
module carrier_lock_ctrl #(
  parameter int ErrW = 8,
  parameter int CntW = 16,
  parameter int AccW = 24,
  parameter int RunW = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   symValid,
  input  logic signed [ErrW-1:0] phaseErr,
  input  logic signed [ErrW-1:0] freqErr,
  input  logic signed [ErrW-1:0] altErr,
  input  logic                   falseSel,
  input  logic                   falseLockEn,
  input  logic [CntW-1:0]        intCount,
  input  logic [AccW-1:0]        lockThresh,
  input  logic [AccW-1:0]        falseThresh,
  input  logic [RunW-1:0]        verifyNeed,
  input  logic [RunW-1:0]        dropNeed,
  input  logic                   haltReq,
  input  logic                   initReq,
  input  logic                   sweepDir,
  input  logic                   hiPwr,
  input  logic                   loPwr,
  output logic [1:0]             lockState,
  output logic                   locked,
  output logic                   acqTrkSel,
  output logic                   sweepEn,
  output logic                   lockIrq,
  output logic                   halted,
  output logic signed [AccW-1:0] phaseSum,
  output logic signed [AccW-1:0] falseSum,
  output logic [7:0]             status
);
  import lockdet_pkg::*;

  ctrlStrobe_t strobe;
  lockSt_t     state;
  logic        resValid, winGood, winFalse;

  lockdet_accum #(.ErrW(ErrW), .CntW(CntW), .AccW(AccW)) u_accum (
    .clk(clk), .rstN(rstN), .strobe(strobe), .symValid(symValid),
    .phaseErr(phaseErr), .freqErr(freqErr), .altErr(altErr),
    .falseSel(falseSel), .intCount(intCount), .lockThresh(lockThresh),
    .falseThresh(falseThresh), .resValid(resValid), .winGood(winGood),
    .winFalse(winFalse), .phaseSum(phaseSum), .falseSum(falseSum)
  );

  lockdet_fsm #(.RunW(RunW)) u_fsm (
    .clk(clk), .rstN(rstN), .resValid(resValid), .winGood(winGood),
    .winFalse(winFalse), .falseLockEn(falseLockEn), .verifyNeed(verifyNeed),
    .dropNeed(dropNeed), .haltReq(haltReq), .initReq(initReq),
    .strobe(strobe), .state(state), .lockIrq(lockIrq), .halted(halted)
  );

  always_comb begin
    lockState = state;
    locked    = (state == ST_TRACK);
    acqTrkSel = locked;
    sweepEn   = (state == ST_SEARCH);
    status    = {1'b0, locked, acqTrkSel, sweepDir, hiPwr, loPwr, halted, 1'b0};
  end
endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker #(
  parameter int AccW = 24
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      lockState,
  input logic            locked,
  input logic            lockIrq,
  input logic            halted,
  input logic            initReq,
  input logic            sweepEn,
  input logic            acqTrkSel,
  input logic [AccW-1:0] phaseSum
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    lockIrq |=> !lockIrq); // R9
  AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (locked != $past(locked)) |-> lockIrq); // R9
  AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == 2'd0) |=> (lockState != 2'd2)); // R3
  AST_TRACK_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == 2'd2) |=> (lockState != 2'd1)); // R7
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !initReq) |=> ($stable(phaseSum) && $stable(lockState))); // R10
  AST_SWEEP_ACQ: assert property (@(posedge clk) disable iff (!rstN)
    sweepEn |-> !acqTrkSel); // R8
endmodule

bind carrier_lock_ctrl lockdet_checker #(.AccW(AccW)) u_chk (
  .clk(clk), .rstN(rstN), .lockState(lockState), .locked(locked),
  .lockIrq(lockIrq), .halted(halted), .initReq(initReq), .sweepEn(sweepEn),
  .acqTrkSel(acqTrkSel), .phaseSum(phaseSum)
);

// File: tb/carrier_lock_ctrl_bench.sv
module carrier_lock_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic symValid = 1'b0;
  logic signed [7:0] phaseErr = '0, freqErr = '0, altErr = '0;
  logic falseSel = 1'b0, falseLockEn = 1'b0;
  logic [15:0] intCount = 16'd4;
  logic [23:0] lockThresh = 24'd20, falseThresh = 24'd30;
  logic [3:0] verifyNeed = 4'd2, dropNeed = 4'd3;
  logic haltReq = 1'b0, initReq = 1'b0;
  logic sweepDir = 1'b1, hiPwr = 1'b0, loPwr = 1'b1;
  logic [1:0] lockState;
  logic locked, acqTrkSel, sweepEn, lockIrq, halted;
  logic signed [23:0] phaseSum, falseSum;
  logic [7:0] status;

  int checks = 0;
  int errors = 0;
  bit expIrq[$];

  always #5 clk = ~clk;

  carrier_lock_ctrl u_carrier_lock_ctrl (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: every lock interrupt must match the next expected lock value
  always @(negedge clk) begin
    if (rstN && lockIrq) begin
      checks++;
      if (expIrq.size() == 0) begin
        errors++;
        $display("FAIL R9: actual unexpected irq, expected none");
      end else begin
        bit e;
        e = expIrq.pop_front();
        if (locked != e) begin
          errors++;
          $display("FAIL R9: actual locked=%0d expected %0d", locked, e);
        end
      end
    end
  end

  task automatic runWin(input int n, input int pe);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      symValid = 1'b1;
      phaseErr = 8'(pe);
    end
    @(negedge clk);
    symValid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseHalt();
    @(negedge clk); haltReq = 1'b1;
    @(negedge clk); haltReq = 1'b0;
  endtask

  task automatic pulseInit();
    @(negedge clk); initReq = 1'b1;
    @(negedge clk); initReq = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R12 reset state
    check("R1 state", lockState, 0);
    check("R1 sweepEn", sweepEn, 1);
    check("R1 acqTrkSel", acqTrkSel, 0);
    check("R1 lockIrq", lockIrq, 0);
    check("R1 halted", halted, 0);
    check("R1 phaseSum", phaseSum, 0);
    check("R12 status", status, 8'h14);

    runWin(4, 10);                 // sum 40, bad
    check("R2 sum", phaseSum, 40);
    check("R3 stay search", lockState, 0);
    runWin(4, 1);                  // sum 4, good
    check("R2 sum good", phaseSum, 4);
    check("R3 to verify", lockState, 1);
    check("R8 sweep off", sweepEn, 0);
    runWin(4, -10);                // sum -40, bad
    check("R2 negative sum", phaseSum, -40);
    check("R4 bad verify", lockState, 0);

    runWin(4, 1);
    check("R3 verify again", lockState, 1);
    falseLockEn = 1'b1; falseSel = 1'b0; freqErr = 8'sd10;
    runWin(4, 1);                  // false sum 40 > 30
    check("R6 freqErr sum", falseSum, 40);
    check("R5 false lock", lockState, 0);

    runWin(4, 1);
    check("R3 verify third", lockState, 1);
    falseLockEn = 1'b0;
    runWin(4, 1);                  // false hit ignored
    check("R5 disabled", lockState, 1);
    falseLockEn = 1'b1; falseSel = 1'b1; altErr = 8'sd0;
    expIrq.push_back(1'b1);
    runWin(4, 1);                  // second good verify
    check("R6 altErr sum", falseSum, 0);
    check("R4 to track", lockState, 2);
    check("R8 locked", locked, 1);
    check("R8 acqTrkSel", acqTrkSel, 1);
    check("R8 sweepEn", sweepEn, 0);
    check("R12 status track", status, 8'h74);

    runWin(4, 10); runWin(4, 10);
    check("R7 hold after 2 bad", lockState, 2);
    runWin(4, 1);
    runWin(4, 10); runWin(4, 10);
    check("R7 count restarted", lockState, 2);
    expIrq.push_back(1'b0);
    runWin(4, 10);
    check("R7 drop", lockState, 0);
    check("R8 unlocked", locked, 0);
    check("R9 queue drained", expIrq.size(), 0);

    pulseHalt();
    check("R10 not yet halted", halted, 0);
    runWin(4, 10);
    check("R10 halted", halted, 1);
    check("R12 halted bit", status[1], 1);
    runWin(4, 1);                  // ignored
    check("R10 sum held", phaseSum, 40);
    check("R10 state held", lockState, 0);
    pulseInit();
    check("R11 halt cleared", halted, 0);
    runWin(2, 10);                 // partial, discarded by init
    pulseInit();
    runWin(4, 1);
    check("R11 acc cleared", phaseSum, 4);
    check("R11 state verify", lockState, 1);

    intCount = 16'd2;
    runWin(2, 10);                 // sum 20 == threshold: bad
    check("R2 short window", phaseSum, 20);
    check("R2 equal is bad", lockState, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule